// File: doc/BRIEF.md
# PLL Retune Sequencer

This block moves a PLL from its present setting to a new output rate without exposing downstream logic to an unlocked clock. A host presents a rate in kHz together with a mode bit (integer or fractional) and pulses a start strobe. The block looks the rate up in a small built-in table of divider settings for that mode. When the lookup succeeds, it walks the PLL control lines through a fixed, safe order. First the output is parked on the reference clock. The PLL is then powered down and the new dividers are loaded. After a settle time the PLL is powered up again. The lock input is sampled after a further wait. Only after these steps does the block return the PLL output to the downstream logic.

Both waits are counted in cycles of the block's own clock, taken from a clock-frequency parameter in MHz. Every request ends with a single-cycle done pulse and a 2-bit result code. A lock failure leaves the PLL parked on the reference. In fractional mode, the block also confirms that the PLL status word reports the new numerator before it removes the bypass.

Top module: `pll_retune_seq`

## Requirements
- R1: After reset the outputs are: bypass 1, power 0, output enable 0, spread-spectrum enable 1, hardware-control select 1, done 0, busy 0, and all divider, numerator and denominator words 0.
- R2: A requested rate with no table entry for the selected mode ends the request with result code 01 (invalid). Done appears in the cycle after start is taken, and no control output or word changes.
- R3: Integer table (rate kHz: ref div, multiplier, out div): 1800000:1,150,2; 1700000:1,141,2; 1500000:1,125,2; 1400000:1,175,3; 1000000:1,166,4; 900000:1,150,4. Fractional table (rate kHz: ref div, multiplier, out div, numerator, denominator): 1000000:1,166,4,2,3; 933000:1,155,4,1,2; 700000:1,145,5,5,6; 484000:1,121,6,0,1; 466000:1,155,8,1,3; 445333:1,167,9,0,1; 400000:1,200,12,0,1; 300000:1,150,12,0,1.
- R4: The divider word holds the output divider in bits 7:0, the reference divider in bits 15:13 and the multiplier in bits 24:16, with all other bits zero. It is loaded only while bypass is 1 and both power and output enable are 0.
- R5: An accepted request acts one step per cycle. In integer mode it clears the hardware-control select one edge after start, sets bypass on the next edge, and clears power and output enable together on the next. It loads the divider word on the edge after that. Fractional mode skips the select step, so each of these actions comes one edge earlier.
- R6: In fractional mode, after the divider load, spread-spectrum enable is cleared. On the next edge the numerator word is loaded with the numerator shifted left by 2, and the denominator word with the denominator masked to 30 bits.
- R7: Power rises SETTLE_US*CLK_MHZ cycles after the last divider, numerator or denominator write. Lock is sampled LOCK_US*CLK_MHZ cycles after power rises.
- R8: If lock is low at the sample point, the request ends with result code 10 (I/O error). Bypass stays 1 and output enable stays 0.
- R9: If lock is high at the sample point, output enable rises on that edge. In fractional mode the next edge compares status bits 31:2 with numerator word bits 31:2, and a mismatch ends the request with code 10 and bypass still 1. Otherwise bypass is cleared on the following edge, the last change, and the result code is 00.
- R10: Done is high for exactly one cycle per request, and the result code is valid while done is high.
- R11: A start strobe while busy is ignored: it produces no extra done and does not change the ongoing request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the wait time base |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, taken when idle |
| frac_mode_i | input | 1 | 1 selects fractional mode and table |
| rate_i | input | 32 | Requested rate in kHz |
| lock_i | input | 1 | PLL lock indication |
| status_i | input | 32 | PLL status word; bits 31:2 echo the active numerator |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | Result: 00 ok, 01 invalid rate, 10 I/O error |
| hw_sel_o | output | 1 | Hardware-control select |
| bypass_o | output | 1 | Park PLL output on the reference clock |
| out_en_o | output | 1 | PLL output enable |
| power_o | output | 1 | PLL power-up |
| ss_en_o | output | 1 | Spread-spectrum enable |
| div_word_o | output | 32 | Packed divider word |
| num_word_o | output | 32 | Numerator word (value shifted left by 2) |
| den_word_o | output | 32 | Denominator word (30 bits used) |

## Verification
Counting edges from the edge that takes start, and with S and L the settle and lock windows in cycles, done is due as follows. An invalid rate gives done after edge 0. An integer lock failure gives it after edge 4+S+L and an integer success after 5+S+L. In fractional mode a failed lock gives done after edge 5+S+L, a numerator mismatch after 6+S+L and a success after 7+S+L. Power rises at edge 4+S (integer) or 5+S (fractional). The scoreboard records the edge index of every control transition, 1 ns after each rising edge, and compares each index and the done index with these formulas. A second sample after each done confirms that the pulse has dropped.

// File: rtl/pll_retune_seq.sv
module pll_retune_seq #(
  parameter int CLK_MHZ   = 24,
  parameter int SETTLE_US = 5,
  parameter int LOCK_US   = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        frac_mode_i,
  input  logic [31:0] rate_i,
  input  logic        lock_i,
  input  logic [31:0] status_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [1:0]  err_o,
  output logic        hw_sel_o,
  output logic        bypass_o,
  output logic        out_en_o,
  output logic        power_o,
  output logic        ss_en_o,
  output logic [31:0] div_word_o,
  output logic [31:0] num_word_o,
  output logic [31:0] den_word_o
);
  localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;
  localparam int LOCK_CYC   = LOCK_US * CLK_MHZ;
  localparam int MAX_CYC    = (LOCK_CYC > SETTLE_CYC) ? LOCK_CYC : SETTLE_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);
  localparam int ODIV_W     = 8;
  localparam int RDIV_W     = 3;
  localparam int MFI_W      = 9;
  localparam int FRAC_W     = 30;
  localparam logic [1:0] ERR_NONE  = 2'd0;
  localparam logic [1:0] ERR_INVAL = 2'd1;
  localparam logic [1:0] ERR_IO    = 2'd2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HWSEL, ST_BYP, ST_OFF, ST_DIV, ST_SS, ST_FRAC,
    ST_SETTLE, ST_LOCK, ST_CHK, ST_UNBYP, ST_DONE
  } st_t;

  st_t               state;
  logic [CNT_W-1:0]  cnt;
  logic              r_frac;
  logic [ODIV_W-1:0] r_odiv, l_odiv;
  logic [RDIV_W-1:0] r_rdiv, l_rdiv;
  logic [MFI_W-1:0]  r_mfi, l_mfi;
  logic [FRAC_W-1:0] r_mfn, l_mfn, r_mfd, l_mfd;
  logic              hit;

  always_comb begin
    hit    = 1'b1;
    l_rdiv = RDIV_W'(1);
    l_mfi  = '0;
    l_odiv = '0;
    l_mfn  = '0;
    l_mfd  = FRAC_W'(1);
    if (!frac_mode_i) begin
      case (rate_i)
        32'd1800000: begin l_mfi = 9'd150; l_odiv = 8'd2; end
        32'd1700000: begin l_mfi = 9'd141; l_odiv = 8'd2; end
        32'd1500000: begin l_mfi = 9'd125; l_odiv = 8'd2; end
        32'd1400000: begin l_mfi = 9'd175; l_odiv = 8'd3; end
        32'd1000000: begin l_mfi = 9'd166; l_odiv = 8'd4; end
        32'd900000:  begin l_mfi = 9'd150; l_odiv = 8'd4; end
        default:     hit = 1'b0;
      endcase
    end else begin
      case (rate_i)
        32'd1000000: begin l_mfi = 9'd166; l_odiv = 8'd4;  l_mfn = 30'd2; l_mfd = 30'd3; end
        32'd933000:  begin l_mfi = 9'd155; l_odiv = 8'd4;  l_mfn = 30'd1; l_mfd = 30'd2; end
        32'd700000:  begin l_mfi = 9'd145; l_odiv = 8'd5;  l_mfn = 30'd5; l_mfd = 30'd6; end
        32'd484000:  begin l_mfi = 9'd121; l_odiv = 8'd6;  end
        32'd466000:  begin l_mfi = 9'd155; l_odiv = 8'd8;  l_mfn = 30'd1; l_mfd = 30'd3; end
        32'd445333:  begin l_mfi = 9'd167; l_odiv = 8'd9;  end
        32'd400000:  begin l_mfi = 9'd200; l_odiv = 8'd12; end
        32'd300000:  begin l_mfi = 9'd150; l_odiv = 8'd12; end
        default:     hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      r_frac     <= 1'b0;
      r_odiv     <= '0;
      r_rdiv     <= '0;
      r_mfi      <= '0;
      r_mfn      <= '0;
      r_mfd      <= '0;
      err_o      <= ERR_NONE;
      hw_sel_o   <= 1'b1;
      bypass_o   <= 1'b1;
      out_en_o   <= 1'b0;
      power_o    <= 1'b0;
      ss_en_o    <= 1'b1;
      div_word_o <= '0;
      num_word_o <= '0;
      den_word_o <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_i) begin
          r_frac <= frac_mode_i;
          r_odiv <= l_odiv;
          r_rdiv <= l_rdiv;
          r_mfi  <= l_mfi;
          r_mfn  <= l_mfn;
          r_mfd  <= l_mfd;
          if (!hit) begin
            err_o <= ERR_INVAL;
            state <= ST_DONE;
          end else begin
            err_o <= ERR_NONE;
            state <= frac_mode_i ? ST_BYP : ST_HWSEL;
          end
        end
        ST_HWSEL: begin
          hw_sel_o <= 1'b0;
          state    <= ST_BYP;
        end
        ST_BYP: begin
          bypass_o <= 1'b1;
          state    <= ST_OFF;
        end
        ST_OFF: begin
          out_en_o <= 1'b0;
          power_o  <= 1'b0;
          state    <= ST_DIV;
        end
        ST_DIV: begin
          div_word_o <= {7'd0, r_mfi, r_rdiv, 5'd0, r_odiv};
          cnt        <= CNT_W'(SETTLE_CYC - 1);
          state      <= r_frac ? ST_SS : ST_SETTLE;
        end
        ST_SS: begin
          ss_en_o <= 1'b0;
          state   <= ST_FRAC;
        end
        ST_FRAC: begin
          num_word_o <= {r_mfn, 2'b00};
          den_word_o <= {2'b00, r_mfd};
          cnt        <= CNT_W'(SETTLE_CYC - 1);
          state      <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (cnt == '0) begin
            power_o <= 1'b1;
            cnt     <= CNT_W'(LOCK_CYC - 1);
            state   <= ST_LOCK;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_LOCK: begin
          if (cnt == '0) begin
            if (lock_i) begin
              out_en_o <= 1'b1;
              state    <= r_frac ? ST_CHK : ST_UNBYP;
            end else begin
              err_o <= ERR_IO;
              state <= ST_DONE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CHK: begin
          if (status_i[31:2] == num_word_o[31:2]) begin
            state <= ST_UNBYP;
          end else begin
            err_o <= ERR_IO;
            state <= ST_DONE;
          end
        end
        ST_UNBYP: begin
          bypass_o <= 1'b0;
          state    <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done_o = (state == ST_DONE);
  assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/pll_retune_seq_chk.sv
module pll_retune_seq_chk #(
  parameter int CLK_MHZ   = 24,
  parameter int SETTLE_US = 5,
  parameter int LOCK_US   = 100
) (
  input logic        clk,
  input logic        rst_n,
  input logic        done_o,
  input logic [1:0]  err_o,
  input logic        bypass_o,
  input logic        power_o,
  input logic        out_en_o,
  input logic        lock_i,
  input logic [31:0] div_word_o,
  input logic [31:0] num_word_o,
  input logic [31:0] den_word_o
);
  localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;
  localparam int LOCK_CYC   = LOCK_US * CLK_MHZ;
  localparam int MAX_CYC    = (LOCK_CYC > SETTLE_CYC) ? LOCK_CYC : SETTLE_CYC;
  localparam int W          = $clog2(MAX_CYC + 2);

  logic [31:0]  div_q, num_q, den_q;
  logic [W-1:0] since_wr, since_pwr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q     <= '0;
      num_q     <= '0;
      den_q     <= '0;
      since_wr  <= '0;
      since_pwr <= '0;
    end else begin
      div_q <= div_word_o;
      num_q <= num_word_o;
      den_q <= den_word_o;
      if (div_word_o != div_q || num_word_o != num_q || den_word_o != den_q)
        since_wr <= '0;
      else if (since_wr != {W{1'b1}})
        since_wr <= since_wr + 1'b1;
      if (!power_o)
        since_pwr <= '0;
      else if (since_pwr != {W{1'b1}})
        since_pwr <= since_pwr + 1'b1;
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_div_safe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_word_o) |-> (bypass_o && !power_o && !out_en_o));
  assert_settle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_o) |-> (bypass_o && !out_en_o && since_wr >= W'(SETTLE_CYC - 1)));
  assert_lock_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en_o) |-> (since_pwr >= W'(LOCK_CYC) && $past(lock_i)));
  assert_unbyp_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bypass_o) |-> (out_en_o && power_o));
  assert_fail_parked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o == 2'd2) |-> bypass_o);
  assert_inval_untouched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o == 2'd1) |-> ($stable(bypass_o) && $stable(power_o) && $stable(div_word_o)));
endmodule

bind pll_retune_seq pll_retune_seq_chk #(
  .CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US), .LOCK_US(LOCK_US)
) u_chk (.*);

// File: tb/test_pll_retune_seq.sv
`timescale 1ns/1ps
module test_pll_retune_seq;
  localparam int MHZ = 20;
  localparam int S = 5 * MHZ;
  localparam int L = 100 * MHZ;

  typedef struct {
    string req;
    int err, lat, t_hw, t_byp, t_pf, t_div, t_ss, t_pr;
    logic [31:0] div, num, den;
    bit byp, oe, hw;
  } exp_t;

  logic clk = 0, rst_n = 0, start_i = 0, frac_mode_i = 0, lock_i = 0;
  logic [31:0] rate_i = 0, status_i;
  logic busy_o, done_o, hw_sel_o, bypass_o, out_en_o, power_o, ss_en_o;
  logic [1:0] err_o;
  logic [31:0] div_word_o, num_word_o, den_word_o;

  int checks = 0, failures = 0;
  bit lock_ok = 1, bad_num = 0, new_run = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  pll_retune_seq #(.CLK_MHZ(MHZ)) i_pll_retune_seq (.*);

  assign status_i = {num_word_o[31:2] ^ {29'd0, bad_num}, 2'b11};

  int pcnt = 0;
  always @(negedge clk) begin
    if (!power_o) pcnt = 0; else pcnt++;
    lock_i = lock_ok && (pcnt > 30);
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(int odiv, int rdiv, int mfi);
    return (32'(mfi) << 16) | (32'(rdiv) << 13) | 32'(odiv);
  endfunction

  // monitor / scoreboard
  initial begin
    int k = 0;
    bit active = 0, want_low = 0;
    int t_hw, t_byp, t_pf, t_div, t_ss, t_pr;
    logic p_hw, p_byp, p_pw, p_ss;
    logic [31:0] p_div;
    exp_t e;
    t_hw = -1; t_byp = -1; t_pf = -1; t_div = -1; t_ss = -1; t_pr = -1;
    p_hw = 1; p_byp = 1; p_pw = 0; p_ss = 1; p_div = 0;
    forever begin
      @(posedge clk); #1;
      if (new_run) begin
        new_run = 0; active = 1; k = 0;
        t_hw = -1; t_byp = -1; t_pf = -1; t_div = -1; t_ss = -1; t_pr = -1;
      end else if (active) k++;
      if (active) begin
        if (p_hw && !hw_sel_o && t_hw < 0) t_hw = k;
        if (!p_byp && bypass_o && t_byp < 0) t_byp = k;
        if (p_pw && !power_o && t_pf < 0) t_pf = k;
        if (p_div != div_word_o && t_div < 0) t_div = k;
        if (p_ss && !ss_en_o && t_ss < 0) t_ss = k;
        if (!p_pw && power_o && t_pr < 0) t_pr = k;
      end
      if (want_low) begin
        chk(!done_o, "R10", "done width", done_o, 0);
        want_low = 0;
      end
      if (rst_n && done_o) begin
        if (q.size() == 0) begin
          chk(0, "R11", "unexpected done", 1, 0);
        end else begin
          e = q.pop_front();
          chk(err_o == e.err, e.req, "result code", err_o, e.err);
          chk(k == e.lat, e.req, "done edge", k, e.lat);
          chk(t_hw == e.t_hw, e.req, "select clear edge", t_hw, e.t_hw);
          chk(t_byp == e.t_byp, e.req, "bypass set edge", t_byp, e.t_byp);
          chk(t_pf == e.t_pf, e.req, "power clear edge", t_pf, e.t_pf);
          chk(t_div == e.t_div, e.req, "divider load edge", t_div, e.t_div);
          chk(t_ss == e.t_ss, e.req, "spread clear edge", t_ss, e.t_ss);
          chk(t_pr == e.t_pr, e.req, "power rise edge", t_pr, e.t_pr);
          chk(div_word_o == e.div, e.req, "divider word", div_word_o, e.div);
          chk(num_word_o == e.num, e.req, "numerator word", num_word_o, e.num);
          chk(den_word_o == e.den, e.req, "denominator word", den_word_o, e.den);
          chk(bypass_o == e.byp, e.req, "final bypass", bypass_o, e.byp);
          chk(out_en_o == e.oe, e.req, "final output enable", out_en_o, e.oe);
          chk(hw_sel_o == e.hw, e.req, "final select", hw_sel_o, e.hw);
        end
        active = 0;
        want_low = 1;
      end
      p_hw = hw_sel_o; p_byp = bypass_o; p_pw = power_o; p_ss = ss_en_o; p_div = div_word_o;
    end
  end

  task automatic run(exp_t e, int rate, bit frac, bit lk, bit bn, bit poke);
    @(negedge clk);
    rate_i = 32'(rate); frac_mode_i = frac; lock_ok = lk; bad_num = bn;
    q.push_back(e);
    new_run = 1;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    if (poke) begin
      repeat (300) @(negedge clk);
      rate_i = 32'd1800000; frac_mode_i = 0;
      start_i = 1;
      @(negedge clk);
      start_i = 0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  function automatic exp_t mk(string req, int err, int lat, int t_hw, int t_byp, int t_pf,
                              int t_div, int t_ss, int t_pr, logic [31:0] div,
                              logic [31:0] num, logic [31:0] den, bit byp, bit oe, bit hw);
    exp_t e;
    e.req = req; e.err = err; e.lat = lat; e.t_hw = t_hw; e.t_byp = t_byp; e.t_pf = t_pf;
    e.t_div = t_div; e.t_ss = t_ss; e.t_pr = t_pr; e.div = div; e.num = num; e.den = den;
    e.byp = byp; e.oe = oe; e.hw = hw;
    return e;
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(bypass_o == 1, "R1", "bypass", bypass_o, 1);
    chk(power_o == 0 && out_en_o == 0, "R1", "power/enable", {power_o, out_en_o}, 0);
    chk(ss_en_o == 1 && hw_sel_o == 1, "R1", "spread/select", {ss_en_o, hw_sel_o}, 3);
    chk(done_o == 0 && busy_o == 0, "R1", "done/busy", {done_o, busy_o}, 0);
    chk(div_word_o == 0 && num_word_o == 0 && den_word_o == 0, "R1", "words", div_word_o, 0);

    // R6 R9 fractional success
    run(mk("R6", 0, 7+S+L, -1, -1, -1, 3, 4, 5+S, pack(4,1,166), 32'd8, 32'd3, 0, 1, 1),
        1000000, 1, 1, 0, 0);
    // R5 R4 R3 integer success
    run(mk("R5", 0, 5+S+L, 1, 2, 3, 4, -1, 4+S, pack(2,1,125), 32'd8, 32'd3, 0, 1, 0),
        1500000, 0, 1, 0, 0);
    // R2 unknown rate, and integer-only rate in fractional mode
    run(mk("R2", 1, 0, -1, -1, -1, -1, -1, -1, pack(2,1,125), 32'd8, 32'd3, 0, 1, 0),
        777, 0, 1, 0, 0);
    run(mk("R2", 1, 0, -1, -1, -1, -1, -1, -1, pack(2,1,125), 32'd8, 32'd3, 0, 1, 0),
        1800000, 1, 1, 0, 0);
    // R8 R7 lock failure
    run(mk("R8", 2, 4+S+L, -1, 2, 3, 4, -1, 4+S, pack(4,1,150), 32'd8, 32'd3, 1, 0, 0),
        900000, 0, 0, 0, 0);
    // R9 numerator mismatch
    run(mk("R9", 2, 6+S+L, -1, -1, 2, 3, -1, 5+S, pack(8,1,155), 32'd4, 32'd3, 1, 1, 0),
        466000, 1, 1, 1, 0);
    // R11 start while busy ignored
    run(mk("R11", 0, 7+S+L, -1, -1, 2, 3, -1, 5+S, pack(5,1,145), 32'd20, 32'd6, 0, 1, 0),
        700000, 1, 1, 0, 1);
    repeat (20) @(negedge clk);
    chk(q.size() == 0 && !busy_o, "R11", "idle after run", busy_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule